// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps the outcome of each finished transmit packet until host software collects it. Each time the transmit engine finishes a packet, it hands over a one-cycle pulse with four outcome flags. The block packs these into an 8-bit status byte and stores it in a small first-in, first-out store. The host sees the oldest stored byte on a registered byte output. Any host write to the status register discards that oldest entry, so the data written does not matter.

When a completion arrives and the store is full, that completion is lost. The next byte that is stored carries a marker bit so the host can tell a result went missing. A jabber or underrun outcome halts the transmitter until a transmit reset command. The block drives a transmit-complete event while any stored entry needs host attention. The transmit reset command clears the store, the lost marker and the halt together.

Top module: `txstat_stack`

## Requirements
- R1: A stored status byte has bit 7 = 1, bit 6 = request-interrupt, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = lost-completion marker, and bits 1:0 = 0. The `done_flags` input maps to these as [3] request-interrupt, [2] jabber, [1] underrun, [0] maximum collisions. A byte pushed into an empty store appears on `status_q` right after the clock edge that accepts it.
- R2: The store holds 4 entries and returns them oldest first.
- R3: A `host_wr` pulse removes the entry shown on `status_q`. A `host_wr` on an empty store is ignored.
- R4: When the store is empty, `status_q` reads 0x00, so bit 7 clear means no status is available.
- R5: A completion that arrives while the store is full, with no pop in the same cycle, is discarded and the stored entries are unchanged. The next completion that is stored has bit 2 set. A completion and a pop in the same cycle on a full store are both accepted, and nothing is lost.
- R6: A completion with jabber or underrun set raises `tx_halt` after the accepting edge, even if that completion is discarded. `tx_halt` stays high through pops and further completions until a transmit reset.
- R7: `tx_cmpl_irq` is high exactly while the store holds an entry with any of bits 6 to 2 set. A successful completion without request-interrupt does not raise it.
- R8: A `tx_reset` pulse empties the store and clears the lost marker and `tx_halt` in one cycle. It takes priority over a push or pop in the same cycle.
- R9: After the synchronous reset `rst`, `status_q` = 0x00, `tx_cmpl_irq` = 0 and `tx_halt` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_valid | input | 1 | One-cycle pulse: a packet has finished |
| done_flags | input | 4 | Outcome flags: [3] request-interrupt, [2] jabber, [1] underrun, [0] maximum collisions |
| host_wr | input | 1 | Host write to the status register; pops the oldest entry |
| tx_reset | input | 1 | Transmit reset command |
| status_q | output | 8 | Oldest stored status byte, or 0x00 when empty |
| tx_cmpl_irq | output | 1 | Transmit-complete event to the interrupt controller |
| tx_halt | output | 1 | Transmitter disabled after a jabber or underrun |

## Verification
A read or write pointer out of step shows at `status_q` on the next edge. It appears as a byte out of order, a stale byte after a pop, or a nonzero byte on an empty store. A wrong occupancy count shows up at the fifth push as a lost or kept completion. The bit 2 marker then appears one entry early or late, and is seen once the host pops down to it. Wrong per-slot attention tracking makes `tx_cmpl_irq` differ from the stored contents on the cycle of the push or pop that changed them. Wrong halt or lost state shows on `tx_halt`, or on the bit 2 of the next stored byte, right after the next completion or transmit reset.

// File: rtl/txs_pkg.sv
package txs_pkg;

  typedef struct packed {
    logic req_irq;
    logic jabber;
    logic underrun;
    logic max_coll;
  } txs_flags_t;

  localparam int STATUS_W = 8;

  // Build the host-visible status byte from the outcome flags and the lost marker
  function automatic logic [STATUS_W-1:0] txs_pack(input txs_flags_t f, input logic lost);
    return {1'b1, f.req_irq, f.jabber, f.underrun, f.max_coll, lost, 2'b00};
  endfunction

  // Entry needs host attention: request-interrupt or any error bit
  function automatic logic txs_needs_attn(input logic [STATUS_W-1:0] b);
    return |b[6:2];
  endfunction

  // Outcomes that stop the transmitter until a transmit reset
  function automatic logic txs_is_fatal(input txs_flags_t f);
    return f.jabber | f.underrun;
  endfunction

endpackage

// File: rtl/txs_store.sv
module txs_store #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_attn,
  input  logic             rd_en,
  output logic [WIDTH-1:0] top_q,
  output logic             attn_q,
  output logic             drop_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_ptr_n, wr_ptr_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [DEPTH-1:0] occ_q, occ_n, att_q, att_n;
  logic             do_pop, do_push;
  logic [WIDTH-1:0] top_n;

  always_comb begin
    do_pop  = rd_en & ~clr & (cnt != '0);
    do_push = wr_en & ~clr & ((cnt != FULL_CNT) | do_pop);
    drop_o  = wr_en & ~clr & ~do_push;
  end

  always_comb begin
    if (clr) begin
      rd_ptr_n = '0;
      wr_ptr_n = '0;
      cnt_n    = '0;
    end else begin
      rd_ptr_n = do_pop  ? bump(rd_ptr) : rd_ptr;
      wr_ptr_n = do_push ? bump(wr_ptr) : wr_ptr;
      cnt_n    = cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  // Per-slot occupancy and attention bits, kept beside the data memory
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_comb begin
      if (clr)
        occ_n[i] = 1'b0;
      else if (do_push && wr_ptr == PTR_W'(i))
        occ_n[i] = 1'b1;
      else if (do_pop && rd_ptr == PTR_W'(i))
        occ_n[i] = 1'b0;
      else
        occ_n[i] = occ_q[i];
      att_n[i] = (do_push && wr_ptr == PTR_W'(i)) ? wr_attn : att_q[i];
    end
  end

  // Next head byte, with bypass when the head slot is written this cycle
  always_comb begin
    if (cnt_n == '0)
      top_n = '0;
    else if (do_push && wr_ptr == rd_ptr_n)
      top_n = wr_data;
    else
      top_n = mem[rd_ptr_n];
  end

  // Data memory without reset so it maps to memory resources
  always_ff @(posedge clk) begin
    if (do_push)
      mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      occ_q  <= '0;
      att_q  <= '0;
      top_q  <= '0;
      attn_q <= 1'b0;
    end else begin
      rd_ptr <= rd_ptr_n;
      wr_ptr <= wr_ptr_n;
      cnt    <= cnt_n;
      occ_q  <= occ_n;
      att_q  <= att_n;
      top_q  <= top_n;
      attn_q <= |(occ_n & att_n);
    end
  end

endmodule

// File: rtl/txs_guard.sv
module txs_guard (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic accept,
  input  logic drop,
  input  logic fatal,
  output logic halt_q,
  output logic lost_q
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      halt_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      if ((accept || drop) && fatal)
        halt_q <= 1'b1;
      if (drop)
        lost_q <= 1'b1;
      else if (accept)
        lost_q <= 1'b0;
    end
  end

endmodule

// File: rtl/txstat_stack.sv
module txstat_stack #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       done_valid,
  input  logic [3:0] done_flags,
  input  logic       host_wr,
  input  logic       tx_reset,
  output logic [7:0] status_q,
  output logic       tx_cmpl_irq,
  output logic       tx_halt
);
  import txs_pkg::*;

  txs_flags_t          flags;
  logic [STATUS_W-1:0] entry;
  logic                lost, drop, accept, fatal;

  always_comb begin
    flags  = txs_flags_t'(done_flags);
    entry  = txs_pack(flags, lost);
    fatal  = txs_is_fatal(flags);
    accept = done_valid & ~tx_reset & ~drop;
  end

  txs_store #(.DEPTH(DEPTH), .WIDTH(STATUS_W)) store_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (tx_reset),
    .wr_en   (done_valid),
    .wr_data (entry),
    .wr_attn (txs_needs_attn(entry)),
    .rd_en   (host_wr),
    .top_q   (status_q),
    .attn_q  (tx_cmpl_irq),
    .drop_o  (drop)
  );

  txs_guard guard_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (tx_reset),
    .accept (accept),
    .drop   (drop),
    .fatal  (fatal),
    .halt_q (tx_halt),
    .lost_q (lost)
  );

endmodule

// File: rtl/txstat_stack_chk.sv
module txstat_stack_chk (
  input logic       clk,
  input logic       rst,
  input logic       done_valid,
  input logic [3:0] done_flags,
  input logic       host_wr,
  input logic       tx_reset,
  input logic [7:0] status_q,
  input logic       tx_cmpl_irq,
  input logic       tx_halt
);

  // R1
  entry_format_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q != 8'h00) |-> (status_q[7] && status_q[1:0] == 2'b00));

  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q == 8'h00 && !done_valid && !tx_reset) |=> (status_q == 8'h00));

  // R6
  halt_set_chk: assert property (@(posedge clk) disable iff (rst)
    (done_valid && (done_flags[2] || done_flags[1]) && !tx_reset) |=> tx_halt);

  // R6
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_halt && !tx_reset) |=> tx_halt);

  // R7
  irq_top_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q[6:2] != 5'b0) |-> tx_cmpl_irq);

  // R7
  irq_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q == 8'h00) |-> !tx_cmpl_irq);

  // R8
  txreset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    tx_reset |=> (status_q == 8'h00 && !tx_cmpl_irq && !tx_halt));

endmodule

bind txstat_stack txstat_stack_chk chk_i (.*);

// File: tb/txstat_stack_tb_top.sv
module txstat_stack_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 5000;
  localparam int NV = 31;

  // Row: {req[20:17], valid[16], flags[15:12], pop[11], trst[10], exp_status[9:2], exp_irq[1], exp_halt[0]}
  // flags: [3] request-interrupt, [2] jabber, [1] underrun, [0] max collisions
  localparam logic [20:0] TBL [NV] = '{
    {4'd1, 1'b1, 4'h0, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0}, // R1 plain success, R7 no irq
    {4'd3, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // R3 pop to empty
    {4'd4, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // R4 pop on empty ignored
    {4'd7, 1'b1, 4'h8, 1'b0, 1'b0, 8'hC0, 1'b1, 1'b0}, // R7 request-interrupt
    {4'd2, 1'b1, 4'h1, 1'b0, 1'b0, 8'hC0, 1'b1, 1'b0}, // R2 head unchanged
    {4'd2, 1'b0, 4'h0, 1'b1, 1'b0, 8'h88, 1'b1, 1'b0}, // R2 second entry
    {4'd2, 1'b1, 4'h0, 1'b0, 1'b0, 8'h88, 1'b1, 1'b0}, // R2
    {4'd2, 1'b1, 4'h0, 1'b0, 1'b0, 8'h88, 1'b1, 1'b0}, // R2
    {4'd2, 1'b1, 4'h0, 1'b0, 1'b0, 8'h88, 1'b1, 1'b0}, // R2 now full
    {4'd5, 1'b1, 4'h8, 1'b0, 1'b0, 8'h88, 1'b1, 1'b0}, // R5 lost on full
    {4'd7, 1'b0, 4'h0, 1'b1, 1'b0, 8'h80, 1'b0, 1'b0}, // R7 no attention left, R5 lost not stored
    {4'd5, 1'b1, 4'h0, 1'b0, 1'b0, 8'h80, 1'b1, 1'b0}, // R5 next stored carries bit 2
    {4'd2, 1'b0, 4'h0, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0}, // R2
    {4'd2, 1'b0, 4'h0, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0}, // R2
    {4'd5, 1'b0, 4'h0, 1'b1, 1'b0, 8'h84, 1'b1, 1'b0}, // R5 marker entry
    {4'd4, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // R4 empty again
    {4'd6, 1'b1, 4'h4, 1'b0, 1'b0, 8'hA0, 1'b1, 1'b1}, // R6 jabber halts
    {4'd6, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1}, // R6 halt survives pop
    {4'd6, 1'b1, 4'h2, 1'b0, 1'b0, 8'h90, 1'b1, 1'b1}, // R6 underrun entry
    {4'd8, 1'b1, 4'h1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0}, // R8 reset beats push and pop
    {4'd2, 1'b1, 4'h0, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0}, // R2
    {4'd2, 1'b1, 4'h0, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0}, // R2
    {4'd2, 1'b1, 4'h0, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0}, // R2
    {4'd2, 1'b1, 4'h0, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0}, // R2 full
    {4'd5, 1'b1, 4'h8, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0}, // R5 push+pop on full
    {4'd5, 1'b0, 4'h0, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0}, // R5
    {4'd5, 1'b0, 4'h0, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0}, // R5
    {4'd5, 1'b0, 4'h0, 1'b1, 1'b0, 8'hC0, 1'b1, 1'b0}, // R5 kept, no bit 2
    {4'd3, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // R3
    {4'd6, 1'b1, 4'h2, 1'b0, 1'b0, 8'h90, 1'b1, 1'b1}, // R6 underrun halts
    {4'd8, 1'b0, 4'h0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0}  // R8 reset alone
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       done_valid = 1'b0;
  logic [3:0] done_flags = 4'h0;
  logic       host_wr = 1'b0;
  logic       tx_reset = 1'b0;
  logic [7:0] status_q;
  logic       tx_cmpl_irq;
  logic       tx_halt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txstat_stack dut_i (
    .clk         (clk),
    .rst         (rst),
    .done_valid  (done_valid),
    .done_flags  (done_flags),
    .host_wr     (host_wr),
    .tx_reset    (tx_reset),
    .status_q    (status_q),
    .tx_cmpl_irq (tx_cmpl_irq),
    .tx_halt     (tx_halt)
  );

  task automatic check(input int req, input logic [7:0] st, input logic irq, input logic halt);
    checks++;
    if (status_q !== st || tx_cmpl_irq !== irq || tx_halt !== halt) begin
      errors++;
      $display("FAIL R%0d: status=%02h irq=%0b halt=%0b expected status=%02h irq=%0b halt=%0b",
               req, status_q, tx_cmpl_irq, tx_halt, st, irq, halt);
    end
  endtask

  // Drive at falling edge, one rising edge, then sample at next falling edge
  task automatic step(input logic v, input logic [3:0] f, input logic p, input logic t);
    done_valid = v;
    done_flags = f;
    host_wr    = p;
    tx_reset   = t;
    @(negedge clk);
    done_valid = 1'b0;
    host_wr    = 1'b0;
    tx_reset   = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check(9, 8'h00, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i][16], TBL[i][15:12], TBL[i][11], TBL[i][10]);
      check(int'(TBL[i][20:17]), TBL[i][9:2], TBL[i][1], TBL[i][0]);
    end

    // R2 distinct patterns in order, full depth
    step(1'b1, 4'h1, 1'b0, 1'b0);
    step(1'b1, 4'h8, 1'b0, 1'b0);
    step(1'b1, 4'h9, 1'b0, 1'b0);
    step(1'b1, 4'h0, 1'b0, 1'b0);
    check(2, 8'h88, 1'b1, 1'b0);
    step(1'b0, 4'h0, 1'b1, 1'b0);
    check(2, 8'hC0, 1'b1, 1'b0);
    step(1'b0, 4'h0, 1'b1, 1'b0);
    check(2, 8'hC8, 1'b1, 1'b0);
    step(1'b0, 4'h0, 1'b1, 1'b0);
    check(2, 8'h80, 1'b0, 1'b0);

    // R5 lost fatal completion still halts, R6
    step(1'b1, 4'h0, 1'b0, 1'b0);
    step(1'b1, 4'h0, 1'b0, 1'b0);
    step(1'b1, 4'h0, 1'b0, 1'b0);
    step(1'b1, 4'h4, 1'b0, 1'b0);
    check(6, 8'h80, 1'b0, 1'b1);

    // R9 synchronous reset mid-stream
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(9, 8'h00, 1'b0, 1'b0);

    // R5 marker must not survive reset: next push plain
    step(1'b1, 4'h0, 1'b0, 1'b0);
    check(5, 8'h80, 1'b0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < MAX_CYCLES; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule